// File: doc/BRIEF.md
# Bounded Quadrature Position Counter

This block keeps a signed 24-bit position count driven by field signals. It runs in one of two modes. In pulse-counter mode, the four field inputs act as count pulse, direction, enable-inhibit and hold-reset. In encoder mode, they act as quadrature channel A, quadrature channel B, index marker and home limit switch. Encoder mode decodes the quadrature pair at one, two or four counts per cycle.

The count does not wrap at the register width. It wraps between an upper and a lower limit that software can load. Software can also load the count directly. A home-search sequencer sets a known position from the encoder. After a home command, count pulses are ignored until the limit switch has been seen. The next rising edge of the marker then loads the home value and counting resumes.

Each field input passes through a two-flop synchronizer before the edge detectors. At most one count step is applied per clock. Software controls and value strobes are sampled directly on the block clock.

Top module: `qpos_counter`

## Requirements
- R1: After reset the count is 0 and the homed flag is 0. The upper limit defaults to 0x7FFFFF and the lower limit defaults to 0x800000.
- R2: In pulse-counter mode (`mode_enc`=0), each rising edge of `in_a` is one count step. The step is down when `in_b`=1 or `sw_down`=1. Otherwise it is up. A change of `in_b` alone never changes the count.
- R3: In pulse-counter mode, a step is applied only when `sw_enable`=1 and `in_c`=0. In encoder mode, only `sw_enable` gates counting.
- R4: While `sw_reset`=1, or while `in_d`=1 in pulse-counter mode, the count is held at the lower limit and pulses are not counted. `sw_reset` also sets the homed flag.
- R5: A down step from the lower limit loads the upper limit. An up step from the upper limit loads the lower limit. Any other step changes the count by exactly one.
- R6: In encoder mode with `rate_sel`=0 (X1), the count changes once per quadrature cycle, on the rising edge of `in_a`. The step is up when `in_b`=0 and down when `in_b`=1.
- R7: With `rate_sel`=1 (X2), both edges of `in_a` count. The step is up when the new `in_a` differs from `in_b`.
- R8: With `rate_sel`=2 or 3 (X4), every edge of either channel counts. An `in_a` edge steps up when `in_a`≠`in_b`, and an `in_b` edge steps up when `in_a`=`in_b`. So a cycle with A leading B counts +4.
- R9: In encoder mode, a `home_cmd` pulse does three things: it captures `wr_value` as the home value, clears the homed flag, and freezes the count.
  - After `in_d`=1 has been seen, the next rising edge of `in_c` loads the home value, sets the homed flag and ends the search.
  - A marker edge before the limit has been seen has no effect.
- R10: A `home_abort` pulse ends the search. Counting resumes and the homed flag stays 0.
- R11: A `load_acc` pulse writes `wr_value` into the count on the next clock edge and sets the homed flag. The `load_upper` and `load_lower` pulses write `wr_value` into the respective limit.
- R12: `status_bit` reports the direction (1 = down) in pulse-counter mode and the homed flag in encoder mode.
- R13: A field-input change that is set up before clock edge 1 first affects the count at clock edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_enc | input | 1 | 1 selects encoder mode, 0 selects pulse-counter mode |
| rate_sel | input | 2 | Quadrature rate: 0 X1, 1 X2, 2/3 X4 |
| in_a | input | 1 | Field input A: pulse or quadrature A |
| in_b | input | 1 | Field input B: direction or quadrature B |
| in_c | input | 1 | Field input C: enable-inhibit or marker |
| in_d | input | 1 | Field input D: hold-reset or home limit |
| sw_enable | input | 1 | Software count enable |
| sw_down | input | 1 | Software down-count select |
| sw_reset | input | 1 | Software hold at the lower limit |
| wr_value | input | 24 | Value for the load strobes and the home command |
| load_acc | input | 1 | Load the count from wr_value |
| load_upper | input | 1 | Load the upper limit from wr_value |
| load_lower | input | 1 | Load the lower limit from wr_value |
| home_cmd | input | 1 | Start a home search (encoder mode) |
| home_abort | input | 1 | Cancel a home search |
| count | output | 24 | Two's-complement position count |
| homed | output | 1 | Homed flag |
| status_bit | output | 1 | Direction or homed, depending on mode |
| count_active | output | 1 | Count steps are currently accepted |
| home_busy | output | 1 | Home search in progress |

## Verification
The assertions take three things for granted:
- The upper limit stays above the lower limit.
- The quadrature channels never change in the same clock.
- A strobe that starts a search is never combined in one cycle with `sw_reset` or `load_acc`.

The stimulus keeps to these assumptions by construction:
- Limits are always loaded in an order that keeps them ordered.
- Every field-input level is held for four clocks, so each change passes the synchronizers alone.
- Each strobe is raised for a single cycle on its own.

The sweeps walk every combination of direction, software down, software enable and inhibit, and every decode rate in both directions. Expected counts come from an arithmetic model of the wrap rule.

// File: rtl/qpos_pkg.sv
package qpos_pkg;
  typedef enum logic [1:0] {
    RATE_X1 = 2'd0,
    RATE_X2 = 2'd1,
    RATE_X4 = 2'd2,
    RATE_X4B = 2'd3
  } rate_e;

  localparam int FIELD_W = 4;
  localparam int FLD_A = 0;
  localparam int FLD_B = 1;
  localparam int FLD_C = 2;
  localparam int FLD_D = 3;
endpackage

// File: rtl/qpos_sync.sv
module qpos_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0][W-1:0] pipe_q;
  logic [DEPTH-1:0][W-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = raw;
    for (int k = 1; k < DEPTH; k++) begin
      pipe_d[k] = pipe_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign lvl  = pipe_q[STAGES-1];
  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/qpos_decode.sv
module qpos_decode
  import qpos_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_enc,
  input  rate_e rate,
  input  logic  a_lvl,
  input  logic  b_lvl,
  input  logic  a_rise,
  input  logic  a_fall,
  input  logic  b_rise,
  input  logic  b_fall,
  input  logic  sw_down,
  output logic  step_up,
  output logic  step_dn,
  output logic  dir_down
);
  logic a_edge;
  logic b_edge;
  logic enc_up;
  logic enc_dn;

  assign a_edge   = a_rise | a_fall;
  assign b_edge   = b_rise | b_fall;
  assign dir_down = b_lvl | sw_down;

  always_comb begin
    enc_up = 1'b0;
    enc_dn = 1'b0;
    unique case (rate)
      RATE_X1: begin
        enc_up = a_rise & ~b_lvl;
        enc_dn = a_rise & b_lvl;
      end
      RATE_X2: begin
        enc_up = a_edge & (a_lvl ^ b_lvl);
        enc_dn = a_edge & ~(a_lvl ^ b_lvl);
      end
      default: begin
        if (a_edge && !b_edge) begin
          enc_up = a_lvl ^ b_lvl;
          enc_dn = ~(a_lvl ^ b_lvl);
        end else if (b_edge && !a_edge) begin
          enc_up = ~(a_lvl ^ b_lvl);
          enc_dn = a_lvl ^ b_lvl;
        end
      end
    endcase
  end

  always_comb begin
    if (mode_enc) begin
      step_up = enc_up;
      step_dn = enc_dn;
    end else begin
      step_up = a_rise & ~dir_down;
      step_dn = a_rise & dir_down;
    end
  end

  assert_one_step_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn}));

  assert_pulse_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_enc && (step_up || step_dn)) |-> a_rise);

  assert_x1_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_enc && rate == RATE_X1 && (step_up || step_dn)) |-> a_rise);
endmodule

// File: rtl/qpos_home.sv
module qpos_home #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_enc,
  input  logic             home_cmd,
  input  logic             home_abort,
  input  logic             limit_lvl,
  input  logic             marker_rise,
  input  logic             load_acc,
  input  logic             sw_reset,
  input  logic [CNT_W-1:0] wr_value,
  output logic             searching,
  output logic             home_load,
  output logic [CNT_W-1:0] home_val,
  output logic             homed
);
  logic             search_q, search_d;
  logic             seen_q, seen_d;
  logic             homed_q, homed_d;
  logic [CNT_W-1:0] hval_q, hval_d;
  logic             start;

  assign start     = home_cmd & mode_enc & ~search_q & ~home_abort;
  assign home_load = search_q & ~home_abort & mode_enc & marker_rise & (seen_q | limit_lvl);

  always_comb begin
    search_d = search_q;
    seen_d   = seen_q;
    hval_d   = hval_q;
    homed_d  = homed_q;
    if (home_abort || !mode_enc) begin
      search_d = 1'b0;
    end else if (start) begin
      search_d = 1'b1;
      seen_d   = 1'b0;
      hval_d   = wr_value;
    end else if (home_load) begin
      search_d = 1'b0;
    end else if (search_q && limit_lvl) begin
      seen_d = 1'b1;
    end
    if (start) begin
      homed_d = 1'b0;
    end else if (home_load || load_acc || sw_reset) begin
      homed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      search_q <= 1'b0;
      seen_q   <= 1'b0;
      homed_q  <= 1'b0;
      hval_q   <= '0;
    end else begin
      search_q <= search_d;
      seen_q   <= seen_d;
      homed_q  <= homed_d;
      hval_q   <= hval_d;
    end
  end

  assign searching = search_q;
  assign home_val  = hval_q;
  assign homed     = homed_q;

  assert_home_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (home_cmd && mode_enc && !searching && !home_abort) |=> (searching && !homed));

  assert_marker_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    home_load |=> (homed && !searching));

  assert_abort_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    home_abort |=> !searching);
endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_enc,
  input  logic [1:0]       rate_sel,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             in_c,
  input  logic             in_d,
  input  logic             sw_enable,
  input  logic             sw_down,
  input  logic             sw_reset,
  input  logic [CNT_W-1:0] wr_value,
  input  logic             load_acc,
  input  logic             load_upper,
  input  logic             load_lower,
  input  logic             home_cmd,
  input  logic             home_abort,
  output logic [CNT_W-1:0] count,
  output logic             homed,
  output logic             status_bit,
  output logic             count_active,
  output logic             home_busy
);
  localparam logic [CNT_W-1:0] UPPER_RST = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] LOWER_RST = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] ONE       = {{(CNT_W-1){1'b0}}, 1'b1};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_i = rst_pipe_q[1];

  // field synchronizers
  logic [FIELD_W-1:0] f_lvl, f_rise, f_fall;

  qpos_sync #(.W(FIELD_W), .STAGES(SYNC_STGS)) sync_i (
    .clk  (clk),
    .rst_n(rst_n_i),
    .raw  ({in_d, in_c, in_b, in_a}),
    .lvl  (f_lvl),
    .rise (f_rise),
    .fall (f_fall)
  );

  // step decoding
  logic step_up, step_dn, dir_down;

  qpos_decode dec_i (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .mode_enc(mode_enc),
    .rate    (rate_e'(rate_sel)),
    .a_lvl   (f_lvl[FLD_A]),
    .b_lvl   (f_lvl[FLD_B]),
    .a_rise  (f_rise[FLD_A]),
    .a_fall  (f_fall[FLD_A]),
    .b_rise  (f_rise[FLD_B]),
    .b_fall  (f_fall[FLD_B]),
    .sw_down (sw_down),
    .step_up (step_up),
    .step_dn (step_dn),
    .dir_down(dir_down)
  );

  // home sequencer
  logic             searching, home_load, homed_i;
  logic [CNT_W-1:0] home_val;

  qpos_home #(.CNT_W(CNT_W)) home_i (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .mode_enc   (mode_enc),
    .home_cmd   (home_cmd),
    .home_abort (home_abort),
    .limit_lvl  (f_lvl[FLD_D]),
    .marker_rise(f_rise[FLD_C]),
    .load_acc   (load_acc),
    .sw_reset   (sw_reset),
    .wr_value   (wr_value),
    .searching  (searching),
    .home_load  (home_load),
    .home_val   (home_val),
    .homed      (homed_i)
  );

  // limits and accumulator
  logic [CNT_W-1:0] upper_q, upper_d;
  logic [CNT_W-1:0] lower_q, lower_d;
  logic [CNT_W-1:0] acc_q, acc_d;
  logic             hold, cnt_en;

  assign hold   = sw_reset | (~mode_enc & f_lvl[FLD_D]);
  assign cnt_en = sw_enable & (mode_enc | ~f_lvl[FLD_C]) & ~hold & ~searching;

  always_comb begin
    upper_d = load_upper ? wr_value : upper_q;
    lower_d = load_lower ? wr_value : lower_q;
  end

  always_comb begin
    acc_d = acc_q;
    if (hold) begin
      acc_d = lower_q;
    end else if (load_acc) begin
      acc_d = wr_value;
    end else if (home_load) begin
      acc_d = home_val;
    end else if (cnt_en && step_up) begin
      acc_d = (acc_q == upper_q) ? lower_q : acc_q + ONE;
    end else if (cnt_en && step_dn) begin
      acc_d = (acc_q == lower_q) ? upper_q : acc_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      upper_q <= UPPER_RST;
      lower_q <= LOWER_RST;
      acc_q   <= '0;
    end else begin
      upper_q <= upper_d;
      lower_q <= lower_d;
      acc_q   <= acc_d;
    end
  end

  assign count        = acc_q;
  assign homed        = homed_i;
  assign status_bit   = mode_enc ? homed_i : dir_down;
  assign count_active = cnt_en;
  assign home_busy    = searching;

  assert_hold_lower_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (hold && !load_lower) |=> (count == lower_q));

  assert_wrap_up_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cnt_en && step_up && !load_acc && acc_q == upper_q && !load_lower)
      |=> (count == lower_q));

  assert_wrap_down_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cnt_en && step_dn && !load_acc && acc_q == lower_q && !load_upper)
      |=> (count == upper_q));

  assert_search_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (searching && !hold && !load_acc && !home_load) |=> $stable(count));

  assert_load_value_R11: assert property (@(posedge clk) disable iff (!rst_n_i)
    (load_acc && !hold) |=> (count == $past(wr_value)));
endmodule

// File: tb/qpos_counter_tb.sv
`timescale 1ns/1ps
module qpos_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_enc, in_a, in_b, in_c, in_d;
  logic [1:0]  rate_sel;
  logic        sw_enable, sw_down, sw_reset;
  logic [23:0] wr_value;
  logic        load_acc, load_upper, load_lower, home_cmd, home_abort;
  logic [23:0] count;
  logic        homed, status_bit, count_active, home_busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [23:0] exp_c, lo, hi;

  always #10 clk = ~clk;

  qpos_counter dut_i (
    .clk(clk), .rst_n(rst_n), .mode_enc(mode_enc), .rate_sel(rate_sel),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
    .sw_enable(sw_enable), .sw_down(sw_down), .sw_reset(sw_reset),
    .wr_value(wr_value), .load_acc(load_acc), .load_upper(load_upper),
    .load_lower(load_lower), .home_cmd(home_cmd), .home_abort(home_abort),
    .count(count), .homed(homed), .status_bit(status_bit),
    .count_active(count_active), .home_busy(home_busy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] model_step(input logic [23:0] v, input bit up,
                                             input logic [23:0] l, input logic [23:0] h);
    if (up) return (v == h) ? l : v + 24'd1;
    else    return (v == l) ? h : v - 24'd1;
  endfunction

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_a();
    in_a = 1'b1; settle();
    in_a = 1'b0; settle();
  endtask

  // kind: 0 count, 1 upper, 2 lower, 3 home, 4 abort
  task automatic strobe(input int kind, input logic [23:0] v);
    wr_value = v;
    case (kind)
      0: load_acc = 1'b1;
      1: load_upper = 1'b1;
      2: load_lower = 1'b1;
      3: home_cmd = 1'b1;
      default: home_abort = 1'b1;
    endcase
    @(negedge clk);
    load_acc = 1'b0; load_upper = 1'b0; load_lower = 1'b0;
    home_cmd = 1'b0; home_abort = 1'b0;
    @(negedge clk);
  endtask

  task automatic quad(input logic av, input logic bv);
    in_a = av; in_b = bv; settle();
  endtask

  task automatic fwd_cycle();
    quad(1, 0); quad(1, 1); quad(0, 1); quad(0, 0);
  endtask

  task automatic rev_cycle();
    quad(0, 1); quad(1, 1); quad(1, 0); quad(0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_enc = 1'b0; rate_sel = 2'd0;
    in_a = 1'b0; in_b = 1'b0; in_c = 1'b0; in_d = 1'b0;
    sw_enable = 1'b0; sw_down = 1'b0; sw_reset = 1'b0; wr_value = '0;
    load_acc = 1'b0; load_upper = 1'b0; load_lower = 1'b0;
    home_cmd = 1'b0; home_abort = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    lo = 24'h800000; hi = 24'h7FFFFF;

    // R1 reset state
    check("R1 count", count, 24'd0);
    check("R1 homed", homed, 1'b0);
    check("R1 busy", home_busy, 1'b0);

    // R13 latency of field input
    sw_enable = 1'b1;
    settle();
    in_a = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R13 not before third edge", count, 24'd0);
    @(negedge clk);
    check("R13 at third edge", count, 24'd1);
    in_a = 1'b0; settle();
    exp_c = 24'd1;

    // R2 / R3 sweep over direction, software down, enable and inhibit
    for (int i = 0; i < 16; i++) begin
      in_b = i[0]; sw_down = i[1]; sw_enable = i[2]; in_c = i[3];
      settle();
      check("R2 direction change alone", count, exp_c);
      pulse_a();
      if (i[2] && !i[3]) exp_c = (i[0] || i[1]) ? exp_c - 24'd1 : exp_c + 24'd1;
      check((i[2] && !i[3]) ? "R2 pulse step" : "R3 inhibited pulse", count, exp_c);
    end
    in_b = 1'b0; sw_down = 1'b0; sw_enable = 1'b1; in_c = 1'b0;
    settle();

    // R1 default limits through wrap, R5
    strobe(0, 24'h7FFFFF);
    pulse_a();
    check("R1 default lower via R5 wrap up", count, 24'h800000);
    sw_down = 1'b1; settle();
    pulse_a();
    check("R1 default upper via R5 wrap down", count, 24'h7FFFFF);
    sw_down = 1'b0; settle();

    // R5 small window, sweep up then down
    strobe(1, 24'd5); hi = 24'd5;
    strobe(2, 24'hFFFFFD); lo = 24'hFFFFFD;
    strobe(0, 24'd3); exp_c = 24'd3;
    check("R11 load count", count, exp_c);
    for (int k = 0; k < 5; k++) begin
      pulse_a();
      exp_c = model_step(exp_c, 1'b1, lo, hi);
      check("R5 up sweep", count, exp_c);
    end
    sw_down = 1'b1; settle();
    for (int k = 0; k < 11; k++) begin
      pulse_a();
      exp_c = model_step(exp_c, 1'b0, lo, hi);
      check("R5 down sweep", count, exp_c);
    end
    check("R12 status down in pulse mode", status_bit, 1'b1);
    sw_down = 1'b0; settle();
    check("R12 status up in pulse mode", status_bit, 1'b0);

    // R4 hold by field input and by software
    pulse_a();
    in_d = 1'b1; settle();
    check("R4 field hold at lower", count, lo);
    pulse_a();
    check("R4 no count while held", count, lo);
    in_d = 1'b0; settle();
    sw_reset = 1'b1; settle();
    pulse_a();
    check("R4 software hold at lower", count, lo);
    check("R4 software hold sets homed", homed, 1'b1);
    sw_reset = 1'b0; settle();

    // restore default window
    strobe(2, 24'h800000); lo = 24'h800000;
    strobe(1, 24'h7FFFFF); hi = 24'h7FFFFF;

    // R6 / R7 / R8 encoder rates
    mode_enc = 1'b1;
    strobe(0, 24'd0); exp_c = 24'd0;
    for (int r = 0; r < 3; r++) begin
      rate_sel = r[1:0];
      settle();
      for (int n = 0; n < 3; n++) fwd_cycle();
      exp_c = exp_c + 24'd3 * (24'd1 << r);
      check(r == 0 ? "R6 forward" : (r == 1 ? "R7 forward" : "R8 forward"), count, exp_c);
      for (int n = 0; n < 3; n++) rev_cycle();
      exp_c = exp_c - 24'd3 * (24'd1 << r);
      check(r == 0 ? "R6 reverse" : (r == 1 ? "R7 reverse" : "R8 reverse"), count, exp_c);
    end
    quad(1, 0);
    check("R8 single edge", count, exp_c + 24'd1);
    quad(0, 0);
    check("R8 single edge back", count, exp_c);

    // R9 home search
    strobe(0, 24'd10);
    check("R12 status is homed in encoder mode", status_bit, 1'b1);
    strobe(3, 24'd100);
    check("R9 search clears homed", homed, 1'b0);
    check("R9 search busy", home_busy, 1'b1);
    fwd_cycle();
    check("R9 count frozen", count, 24'd10);
    in_c = 1'b1; settle(); in_c = 1'b0; settle();
    check("R9 marker before limit ignored", count, 24'd10);
    check("R9 still searching", home_busy, 1'b1);
    in_d = 1'b1; settle(); in_d = 1'b0; settle();
    in_c = 1'b1; settle(); in_c = 1'b0; settle();
    check("R9 home value loaded", count, 24'd100);
    check("R9 homed set", homed, 1'b1);
    check("R9 search ended", home_busy, 1'b0);
    fwd_cycle();
    check("R9 counting resumed", count, 24'd104);

    // R10 abort
    strobe(3, 24'd7);
    strobe(4, 24'd0);
    fwd_cycle();
    check("R10 counting after abort", count, 24'd108);
    check("R10 homed stays clear", homed, 1'b0);
    check("R10 not busy", home_busy, 1'b0);
    check("R12 status follows homed", status_bit, 1'b0);

    // R11 load negative value
    strobe(0, 24'hFFFFCE);
    check("R11 negative load", count, 24'hFFFFCE);
    check("R11 load sets homed", homed, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule